// File: doc/BRIEF.md
# Serial Receive Queue with Data-Ready and Interrupt Identification

This block sits on the receive side of a 16550-style serial controller. It takes bytes from the deserializer and holds them in a 16-entry queue. The host reads them back one at a time through a single receive buffer port, and the oldest byte always appears there first. The block produces the data-ready status bit, a 4-bit interrupt identification code and an interrupt line.

The interrupt has two causes. The first is a fill-level interrupt, raised while the queue count is at or above a threshold that the host selects. The second is a character-timeout interrupt. It is raised when bytes remain in the queue but, for four character times, no new byte has arrived and the host has made no read.

The character time is counted in bit-time ticks. A frame with two stop bits takes one more tick per character. With the queue disabled, the block acts as a plain one-byte holding register.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: In queue mode (`fifo_en_i`=1) up to 16 bytes are held in arrival order. `rd_data_o` shows the oldest byte, and a `rd_i` strobe removes it. A read strobe while empty changes nothing.
- R2: `data_ready_o` is 1 exactly when at least one byte is held.
- R3: With `fifo_en_i`=1 and `rx_ie_i`=1, `trig_sel_i` values 00/01/10/11 select thresholds of 1/4/8/14 bytes. While the count is at or above the threshold and no timeout is pending, `iid_o`=4'h4 and `irq_o`=1.
- R4: With no cause pending, or with `rx_ie_i`=0, `iid_o`=4'h1 and `irq_o`=0.
- R5: One character time is DATA_BITS+2 bit ticks with one stop bit, or DATA_BITS+3 ticks with `two_stop_i`=1. At the defaults this gives 40 or 44 ticks for four characters. With `fifo_en_i`=1, `rx_ie_i`=1 and the queue not empty, the timeout becomes pending once four character times of ticks have been counted. While it is pending, `iid_o`=4'hC and `irq_o`=1, and it takes precedence over code 4'h4.
- R6: A byte arrival or a `rd_i` strobe clears a pending timeout and restarts the tick count from zero.
- R7: In queue mode, a byte arriving while 16 are held, with no read in the same cycle, is dropped. It sets `overrun_o`, which stays 1 until reset.
- R8: With `fifo_en_i`=0, a single byte is held and a new arrival overwrites an unread one without setting `overrun_o`. With `rx_ie_i`=1, a held byte gives `iid_o`=4'h4. Code 4'hC never appears in this mode.
- R9: Any change of `fifo_en_i` empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Byte-received strobe |
| rx_data_i | input | 8 | Received byte |
| rd_i | input | 1 | Host read strobe for the receive buffer |
| fifo_en_i | input | 1 | Queue mode enable |
| rx_ie_i | input | 1 | Receive interrupt enable |
| trig_sel_i | input | 2 | Fill threshold select |
| two_stop_i | input | 1 | Frame uses two stop bits |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| rd_data_o | output | 8 | Oldest held byte |
| data_ready_o | output | 1 | At least one byte held |
| iid_o | output | 4 | Interrupt identification code |
| irq_o | output | 1 | Interrupt line |
| overrun_o | output | 1 | Sticky queue overrun flag |

## Verification
The assertions assume that every strobe input is a one-cycle pulse sampled on the rising clock edge. They assume that configuration inputs are held steady while bytes are in flight, and that no bit tick lands in the cycle of an arrival or read. The bench drives all inputs on falling edges and moves configuration only while the queue is empty or being flushed. It also spaces its tick bursts apart from its arrival and read strobes. Under those conditions the timeout boundary can be counted exactly to the tick, which the bench does at both stop-bit settings.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam logic [3:0] IID_NONE = 4'h1;
  localparam logic [3:0] IID_RDA  = 4'h4;
  localparam logic [3:0] IID_CTO  = 4'hC;

  function automatic int trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  input  logic             flush_i,
  input  logic             hold_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CW-1:0]    count_o,
  output logic             overrun_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    rd_ptr_q, wr_ptr_q;
  logic [CW-1:0]    count_q;
  logic             ovr_q;

  logic pop_ok, push_ok, overwrite, drop;

  always_comb begin
    pop_ok    = pop_i && (count_q != '0) && !flush_i;
    overwrite = push_i && !flush_i && hold_i && (count_q != '0) && !pop_ok;
    push_ok   = push_i && !flush_i && !overwrite && ((count_q != DEPTH_C) || pop_ok);
    drop      = push_i && !flush_i && !hold_i && (count_q == DEPTH_C) && !pop_ok;
  end

  always_ff @(posedge clk_i) begin
    if (push_ok)   mem_q[wr_ptr_q] <= data_i;
    if (overwrite) mem_q[rd_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
      ovr_q    <= 1'b0;
    end else begin
      if (drop) ovr_q <= 1'b1;
      if (flush_i) begin
        rd_ptr_q <= '0;
        wr_ptr_q <= '0;
        count_q  <= '0;
      end else begin
        if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
        if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
        if (push_ok && !pop_ok)      count_q <= count_q + 1'b1;
        else if (pop_ok && !push_ok) count_q <= count_q - 1'b1;
      end
    end
  end

  assign head_o    = mem_q[rd_ptr_q];
  assign count_o   = count_q;
  assign overrun_o = ovr_q;

  assert_push_grows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !flush_i && !hold_i && count_q < DEPTH_C)
      |=> (count_q == $past(count_q) + 1'b1));

  assert_drop_keeps_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> ($stable(count_q) && ovr_q));

  assert_hold_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && $past(hold_i)) |-> (count_q <= 1));
endmodule

// File: rtl/rx_char_timer.sv
module rx_char_timer #(
  parameter int DATA_BITS = 8,
  parameter int TO_CHARS  = 4,
  localparam int LIM1 = TO_CHARS * (DATA_BITS + 2),
  localparam int LIM2 = TO_CHARS * (DATA_BITS + 3),
  localparam int TW   = $clog2(LIM2 + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic armed_i,
  input  logic bit_tick_i,
  input  logic two_stop_i,
  output logic expired_o
);
  logic [TW-1:0] cnt_q, limit;

  assign limit = two_stop_i ? TW'(LIM2) : TW'(LIM1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (restart_i || !armed_i)     cnt_q <= '0;
    else if (bit_tick_i && cnt_q < limit) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = armed_i && (cnt_q >= limit);

  assert_restart_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !expired_o);
endmodule

// File: rtl/rx_iid_encode.sv
module rx_iid_encode
  import uart_rx_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          ie_i,
  input  logic [CW-1:0] count_i,
  input  logic [1:0]    trig_sel_i,
  input  logic          expired_i,
  output logic [3:0]    iid_o,
  output logic          irq_o
);
  always_comb begin
    iid_o = IID_NONE;
    if (ie_i) begin
      if (fifo_en_i) begin
        if (expired_i)                                  iid_o = IID_CTO;
        else if (int'(count_i) >= trig_level(trig_sel_i)) iid_o = IID_RDA;
      end else if (count_i != '0) begin
        iid_o = IID_RDA;
      end
    end
  end

  assign irq_o = (iid_o != IID_NONE);

  assert_cto_needs_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iid_o == IID_CTO) |-> (count_i != '0 && fifo_en_i));
endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq #(
  parameter int DEPTH     = 16,
  parameter int DATA_BITS = 8,
  parameter int TO_CHARS  = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_valid_i,
  input  logic [DATA_BITS-1:0] rx_data_i,
  input  logic                 rd_i,
  input  logic                 fifo_en_i,
  input  logic                 rx_ie_i,
  input  logic [1:0]           trig_sel_i,
  input  logic                 two_stop_i,
  input  logic                 bit_tick_i,
  output logic [DATA_BITS-1:0] rd_data_o,
  output logic                 data_ready_o,
  output logic [3:0]           iid_o,
  output logic                 irq_o,
  output logic                 overrun_o
);
  logic          mode_q, flush, expired;
  logic [CW-1:0] count;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= fifo_en_i;
  end
  assign flush = (mode_q != fifo_en_i);

  rx_byte_queue #(.DEPTH(DEPTH), .WIDTH(DATA_BITS)) u_queue (
    .clk_i, .rst_ni,
    .push_i   (rx_valid_i),
    .data_i   (rx_data_i),
    .pop_i    (rd_i),
    .flush_i  (flush),
    .hold_i   (!fifo_en_i),
    .head_o   (rd_data_o),
    .count_o  (count),
    .overrun_o(overrun_o)
  );

  rx_char_timer #(.DATA_BITS(DATA_BITS), .TO_CHARS(TO_CHARS)) u_timer (
    .clk_i, .rst_ni,
    .restart_i (rx_valid_i || rd_i || flush),
    .armed_i   (fifo_en_i && count != '0),
    .bit_tick_i(bit_tick_i),
    .two_stop_i(two_stop_i),
    .expired_o (expired)
  );

  rx_iid_encode #(.CW(CW)) u_iid (
    .clk_i, .rst_ni,
    .fifo_en_i (fifo_en_i),
    .ie_i      (rx_ie_i),
    .count_i   (count),
    .trig_sel_i(trig_sel_i),
    .expired_i (expired),
    .iid_o     (iid_o),
    .irq_o     (irq_o)
  );

  assign data_ready_o = (count != '0);

  assert_quiet_when_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ie_i |-> !irq_o);

  assert_ready_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_ready_o) |-> $past(rx_valid_i));
endmodule

// File: tb/uart_rx_fifo_irq_test.sv
module uart_rx_fifo_irq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rd = 0, fifo_en = 0, rx_ie = 0, two_stop = 0, bit_tick = 0;
  logic [7:0] rx_data = '0;
  logic [1:0] trig_sel = '0;
  logic [7:0] rd_data;
  logic dr, irq, ovr;
  logic [3:0] iid;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_rx_fifo_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rd_i(rd), .fifo_en_i(fifo_en), .rx_ie_i(rx_ie), .trig_sel_i(trig_sel),
    .two_stop_i(two_stop), .bit_tick_i(bit_tick), .rd_data_o(rd_data),
    .data_ready_o(dr), .iid_o(iid), .irq_o(irq), .overrun_o(ovr));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1; rx_data = b; @(negedge clk); rx_valid = 0;
  endtask

  task automatic pop(output logic [7:0] b);
    b = rd_data; rd = 1; @(negedge clk); rd = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin bit_tick = 1; @(negedge clk); bit_tick = 0; end
  endtask

  task automatic flush_fifo();
    fifo_en = 0; @(negedge clk); fifo_en = 1; @(negedge clk);
  endtask

  function automatic logic [3:0] exp_iid(input int cnt, input int thr);
    return (cnt >= thr) ? 4'h4 : 4'h1;
  endfunction

  initial begin
    logic [7:0] b;
    int thr;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    check("reset R2 ready", dr, 0);
    check("reset R4 iid", iid, 4'h1);
    check("reset R4 irq", irq, 0);
    check("reset R7 overrun", ovr, 0);

    rx_ie = 1;
    // R1 R2 R3 threshold sweep
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      thr = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
      flush_fifo();
      for (int i = 1; i <= 16; i++) begin
        push(8'(s * 16 + i));
        check("R2 ready fill", dr, 1);
        check("R3 iid fill", iid, exp_iid(i, thr));
        check("R3 irq fill", irq, (i >= thr));
      end
      for (int k = 0; k < 16; k++) begin
        pop(b);
        check("R1 order", b, 8'(s * 16 + k + 1));
        check("R3 iid drain", iid, exp_iid(15 - k, thr));
        check("R2 ready drain", dr, (15 - k) > 0);
      end
    end

    // R1 read while empty has no effect
    rd = 1; @(negedge clk); rd = 0;
    check("R1 empty read", dr, 0);
    push(8'h5A);
    check("R1 after empty read", rd_data, 8'h5A);
    pop(b);
    check("R1 single", dr, 0);

    // R5 R6 timeout, one stop bit
    trig_sel = 2'b11;
    push(8'hA1); push(8'hA2);
    ticks(39);
    check("R5 before limit", iid, 4'h1);
    ticks(1);
    check("R5 at limit", iid, 4'hC);
    check("R5 irq", irq, 1);
    pop(b);
    check("R6 read clears", iid, 4'h1);
    ticks(39);
    check("R6 restart by read", iid, 4'h1);
    ticks(1);
    check("R5 again", iid, 4'hC);
    push(8'hA3);
    check("R6 arrival clears", iid, 4'h1);
    ticks(40);
    check("R5 after arrival", iid, 4'hC);

    // R5 two stop bits
    two_stop = 1;
    flush_fifo();
    push(8'hB1);
    ticks(43);
    check("R5 two-stop before", iid, 4'h1);
    ticks(1);
    check("R5 two-stop at", iid, 4'hC);
    two_stop = 0;

    // R5 precedence over data-available
    trig_sel = 2'b00;
    flush_fifo();
    push(8'hC1);
    check("R3 code 4", iid, 4'h4);
    ticks(40);
    check("R5 precedence", iid, 4'hC);
    pop(b);
    check("R4 empty", iid, 4'h1);

    // R4 interrupts disabled
    rx_ie = 0;
    for (int i = 0; i < 16; i++) push(8'(i));
    check("R4 disabled iid", iid, 4'h1);
    check("R4 disabled irq", irq, 0);
    ticks(44);
    check("R4 disabled timeout", iid, 4'h1);
    rx_ie = 1;

    // R9 mode change flushes
    fifo_en = 0; @(negedge clk);
    check("R9 flush", dr, 0);

    // R8 holding register mode
    push(8'h11);
    check("R8 iid", iid, 4'h4);
    push(8'h22);
    check("R8 single", dr, 1);
    ticks(50);
    check("R8 no timeout", iid, 4'h4);
    pop(b);
    check("R8 overwrite", b, 8'h22);
    check("R8 empty", dr, 0);
    check("R8 no overrun", ovr, 0);

    // R7 overrun
    fifo_en = 1; @(negedge clk);
    for (int i = 0; i < 16; i++) push(8'(8'h40 + i));
    check("R7 no overrun yet", ovr, 0);
    push(8'hEE);
    check("R7 overrun set", ovr, 1);
    for (int k = 0; k < 16; k++) begin
      pop(b);
      check("R7 kept bytes", b, 8'(8'h40 + k));
    end
    check("R7 dropped", dr, 0);
    check("R7 sticky", ovr, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule